// File: doc/BRIEF.md
# Serial ADC Slave Emulator

This block stands in for the device side of an 8-channel, 10-bit serial analog-to-digital converter. It sits on an SPI-style link that runs in clock mode 0. The block runs on a fast system clock and oversamples the chip-select, serial clock and command-data lines. From those samples it rebuilds the command frame: a start bit, a mode bit and a three-bit channel number. A sample window of two falling clock edges follows the command. After the window, the block drives a zero null bit and then returns a 10-bit result, most significant bit first.

No analog conversion takes place. The result for each channel comes from a small register file that the surrounding logic or a test environment loads through a write port. The serial output is split into a data bit and an output-enable bit, so a pad or a bus model can apply high impedance outside the block. The block reports the mode and channel of the last decoded command. It also flags a frame that chip-select cut short.

Top module: `spi_adc_slave`

## Requirements
- R1: During and after reset, `miso_oe`, `miso_data`, `mode_single`, `chan_sel` and `abort_pulse` are 0, and every channel register holds 0.
- R2: While chip-select is high the output is disabled and `miso_data` is 0. A rising chip-select returns the block to idle, where it waits for the next falling chip-select.
- R3: While selected, the block ignores zeros on `mosi`. The first 1 sampled on a rising `sclk` edge is the start bit.
- R4: The bit sampled on the rising edge after the start bit is the mode: 1 gives single-ended (`mode_single`=1), 0 gives differential (`mode_single`=0).
- R5: The next three rising edges capture the channel number, most significant bit first. `chan_sel` and `mode_single` take the new values once the third bit is in, and they hold them until the next full decode.
- R6: The output stays disabled through the first falling edge after the last channel bit. On the second falling edge, `miso_oe` goes to 1 with `miso_data`=0 (the null bit).
- R7: Each of the next ten falling edges presents one result bit, most significant first. Falling edges after the least significant bit drive 0 while the output stays enabled.
- R8: The selected channel's value is captured when the null bit is presented. A write to that channel later in the frame does not change the bits being sent.
- R9: When `wr_en` is 1 on a clock edge, `wr_data` is stored in channel register `wr_addr`, whatever the serial state, and later frames on that channel return it.
- R10: A chip-select rise after the start bit and before the least significant bit has been presented gives `abort_pulse` high for exactly one cycle. A rise before any start bit, or after the least significant bit, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select from the master, active low, asynchronous |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| mosi | input | 1 | Command data from the master, asynchronous |
| wr_en | input | 1 | Channel register write strobe |
| wr_addr | input | 3 | Channel register index |
| wr_data | input | 10 | Value to store for the channel |
| miso_data | output | 1 | Serial result bit |
| miso_oe | output | 1 | Output enable for the serial result |
| mode_single | output | 1 | Last decoded mode, 1 = single-ended |
| chan_sel | output | 3 | Last decoded channel number |
| abort_pulse | output | 1 | One-cycle flag for a frame cut short |

## Verification
Frames are sent with no leading zeros and with three leading zeros, which separates a decoder that treats the first clock as the start bit from one that hunts for the first 1. Both mode values are used across different channels, which exposes swapped or reversed channel bits. Result patterns include all ones, all zeros and mixed values, which shows whether the bit order is right and whether the null bit sits before the data or inside it. A write in the middle of a frame, a chip-select rise before the start bit, one rise mid-command and one after the last bit, plus a reset after loading the registers, separate the latch point, the abort rule and the clearing of the register file.

// File: rtl/spi_adc_slave.sv
module spi_adc_slave #(
  parameter int NCH  = 8,
  parameter int RES  = 10,
  parameter int SYNC = 2,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           mosi,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_addr,
  input  logic [RES-1:0] wr_data,
  output logic           miso_data,
  output logic           miso_oe,
  output logic           mode_single,
  output logic [CHW-1:0] chan_sel,
  output logic           abort_pulse
);

  localparam int CW        = $clog2(RES + 1);
  localparam int WIN_FALLS = 2;

  typedef enum logic [2:0] {IDLE, HUNT, MODE, CHAN, WIN, XFER, DONE} st_t;

  logic [SYNC-1:0] cs_sr, sclk_sr, din_sr;
  logic            cs_q, sclk_q;
  logic            cs_s, sclk_s, din_s;
  logic            cs_rise, cs_fall, sclk_rise, sclk_fall;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [CHW-1:0]  ch_q;
  logic            mode_q;
  logic [RES-1:0]  sh;
  logic            dat, oe, abort_q, mode_o;
  logic [CHW-1:0]  chan_o;
  logic [RES-1:0]  regs [NCH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sr   <= '1;
      sclk_sr <= '0;
      din_sr  <= '0;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      cs_sr   <= {cs_sr[SYNC-2:0], cs_n};
      sclk_sr <= {sclk_sr[SYNC-2:0], sclk};
      din_sr  <= {din_sr[SYNC-2:0], mosi};
      cs_q    <= cs_s;
      sclk_q  <= sclk_s;
    end

  assign cs_s      = cs_sr[SYNC-1];
  assign sclk_s    = sclk_sr[SYNC-1];
  assign din_s     = din_sr[SYNC-1];
  assign cs_rise   = cs_s & ~cs_q;
  assign cs_fall   = ~cs_s & cs_q;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      ch_q    <= '0;
      mode_q  <= 1'b0;
      sh      <= '0;
      dat     <= 1'b0;
      oe      <= 1'b0;
      abort_q <= 1'b0;
      mode_o  <= 1'b0;
      chan_o  <= '0;
    end else begin
      abort_q <= 1'b0;
      if (cs_rise) begin
        abort_q <= (st == MODE) || (st == CHAN) || (st == WIN) || (st == XFER);
        st      <= IDLE;
        oe      <= 1'b0;
        dat     <= 1'b0;
      end else begin
        case (st)
          IDLE: if (cs_fall) st <= HUNT;
          HUNT: if (sclk_rise && din_s) st <= MODE;
          MODE: if (sclk_rise) begin
            mode_q <= din_s;
            cnt    <= CW'(CHW);
            st     <= CHAN;
          end
          CHAN: if (sclk_rise) begin
            ch_q <= {ch_q[CHW-2:0], din_s};
            cnt  <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
              mode_o <= mode_q;
              chan_o <= {ch_q[CHW-2:0], din_s};
              cnt    <= CW'(WIN_FALLS);
              st     <= WIN;
            end
          end
          WIN: if (sclk_fall) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
              oe  <= 1'b1;
              dat <= 1'b0;
              sh  <= regs[ch_q];
              cnt <= CW'(RES);
              st  <= XFER;
            end
          end
          XFER: if (sclk_fall) begin
            dat <= sh[RES-1];
            sh  <= {sh[RES-2:0], 1'b0};
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) st <= DONE;
          end
          DONE: if (sclk_fall) dat <= 1'b0;
          default: st <= IDLE;
        endcase
      end
    end

  assign miso_data   = dat;
  assign miso_oe     = oe;
  assign mode_single = mode_o;
  assign chan_sel    = chan_o;
  assign abort_pulse = abort_q;

endmodule

// File: rtl/spi_adc_slave_chk.sv
module spi_adc_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_q,
  input logic sclk_fall,
  input logic miso_oe,
  input logic miso_data,
  input logic abort_pulse
);

  // R2
  desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !miso_oe);

  // R2
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso_data);

  // R6
  null_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> !miso_data);

  // R7
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$past(sclk_fall)) |-> $stable(miso_data));

  // R10
  abort_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  // R10
  abort_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !miso_oe);

endmodule

bind spi_adc_slave spi_adc_slave_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .cs_q(cs_q),
  .sclk_fall(sclk_fall),
  .miso_oe(miso_oe),
  .miso_data(miso_data),
  .abort_pulse(abort_pulse)
);

// File: tb/spi_adc_slave_bench.sv
module spi_adc_slave_bench;

  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic       miso_data, miso_oe, mode_single, abort_pulse;
  logic [2:0] chan_sel;

  int total = 0, fails = 0, aborts = 0;

  always #5 clk = ~clk;

  spi_adc_slave u_spi_adc_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .miso_data(miso_data), .miso_oe(miso_oe), .mode_single(mode_single),
    .chan_sel(chan_sel), .abort_pulse(abort_pulse)
  );

  always @(negedge clk) if (abort_pulse) aborts++;

  function automatic logic [9:0] pat(input int k);
    if (k == 7) return 10'h3FF;
    if (k == 0) return 10'h000;
    return 10'((k * 181 + 37) % 1024);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bit_clk(input logic d);
    mosi = d;
    tick(H); sclk = 1'b1;
    tick(H); sclk = 1'b0;
  endtask

  task automatic frame(input int zeros, input logic sgl, input int ch,
                       input logic [9:0] exp, input logic mid_wr, input logic [9:0] mid_val);
    int a0;
    logic [2:0] c;
    c = 3'(ch);
    a0 = aborts;
    cs_n = 1'b0; tick(H);
    for (int i = 0; i < zeros; i++) begin
      bit_clk(1'b0);
      tick(H); chk("R3 no start on zeros", miso_oe, 0);
    end
    bit_clk(1'b1);
    bit_clk(sgl);
    for (int i = 2; i >= 0; i--) bit_clk(c[i]);
    tick(H);
    chk("R4 mode", mode_single, sgl);
    chk("R5 channel", chan_sel, c);
    chk("R6 off after first window fall", miso_oe, 0);
    bit_clk(1'b0); tick(H);
    chk("R6 enabled", miso_oe, 1);
    chk("R6 null bit", miso_data, 0);
    if (mid_wr) wr(ch, mid_val);
    for (int i = 9; i >= 0; i--) begin
      bit_clk(1'b0); tick(H);
      chk(mid_wr ? "R8 latched bit" : "R7 data bit", miso_data, exp[i]);
    end
    bit_clk(1'b0); tick(H);
    chk("R7 zero after LSB", {miso_oe, miso_data}, 2'b10);
    cs_n = 1'b1; tick(H);
    chk("R2 released", {miso_oe, miso_data}, 2'b00);
    chk("R10 no abort after LSB", aborts - a0, 0);
    tick(H);
  endtask

  task automatic t_reset;
    chk("R1 reset outputs", {miso_oe, miso_data, mode_single, chan_sel, abort_pulse}, 0);
    tick(4); rst_n = 1'b1; tick(4);
    chk("R1 after release", {miso_oe, miso_data, mode_single, chan_sel, abort_pulse}, 0);
  endtask

  task automatic t_basic;
    for (int k = 0; k < 8; k++) wr(k, pat(k));
    frame(0, 1'b1, 5, pat(5), 1'b0, '0);
    frame(3, 1'b0, 2, pat(2), 1'b0, '0);
    frame(1, 1'b1, 7, pat(7), 1'b0, '0);
    frame(0, 1'b0, 0, pat(0), 1'b0, '0);
  endtask

  task automatic t_latch;
    frame(0, 1'b1, 3, pat(3), 1'b1, 10'h2A5);
    frame(0, 1'b1, 3, 10'h2A5, 1'b0, '0);
    chk("R9 write seen next frame", chan_sel, 3);
  endtask

  task automatic t_abort;
    int a0;
    a0 = aborts;
    cs_n = 1'b0; tick(H);
    bit_clk(1'b0); bit_clk(1'b0);
    cs_n = 1'b1; tick(H);
    chk("R10 no abort before start", aborts - a0, 0);
    tick(H);
    cs_n = 1'b0; tick(H);
    bit_clk(1'b1); bit_clk(1'b0); bit_clk(1'b1);
    cs_n = 1'b1; tick(H);
    chk("R10 abort mid command", aborts - a0, 1);
    chk("R2 off after abort", miso_oe, 0);
    tick(H);
    frame(0, 1'b0, 6, pat(6), 1'b0, '0);
    chk("R2 idle rearmed", aborts - a0, 1);
  endtask

  task automatic t_reset_clears;
    rst_n = 1'b0; tick(3);
    chk("R1 reset outputs mid run", {miso_oe, mode_single, chan_sel}, 0);
    rst_n = 1'b1; tick(4);
    frame(0, 1'b1, 5, 10'h000, 1'b0, '0);
  endtask

  initial begin
    tick(2);
    t_reset;
    t_basic;
    t_latch;
    t_abort;
    t_reset_clears;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1500000;
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule